// File: doc/BRIEF.md
# Receive Jitter Attenuator Elastic Store

This block sits in the receive path behind clock recovery. Each bit that arrives on the recovered-clock strobe goes into a small bit-wide elastic store. A digital phase accumulator, clocked by a faster system clock, produces a steadier read strobe. On every system cycle the accumulator increment is nudged up or down by the sign of the store's fill error, so the read rate follows the average incoming rate and ignores short-term wander.

The store holds either 32 or 64 bits. How hard the loop pulls back toward the centre depends on the line mode. T1 uses one fixed narrow setting. E1 offers a faster and a slower setting, and the slower one always uses the 64-bit store. When the fill comes within a small guard band of empty or full, the loop drops to wide bandwidth and follows the input jitter instead of smoothing it. It goes back to narrow smoothing once the fill leaves that band. A real collision sets a one-cycle flag and re-centres the pointers. With the block disabled, data and strobe pass straight through.

Top module: `rx_jitter_smoother`

## Requirements
- R1: The effective depth D is 64 when `deep_sel`=1, or when `line_e1`=1 and `e1_slow_bw`=1. Otherwise D is 32, and `e1_slow_bw` has no effect in T1 mode (`line_e1`=0). On the first enabled cycle the store re-initialises, and `lvl` reads D/2 one cycle later.
- R2: Bits leave on `rd_bit`, qualified by `rd_stb`, in the order they were written. After each re-initialisation, the first D/2 bits read are 0.
- R3: A write strobe when `lvl`=D, with no read in that cycle, is an overflow. `ovf` pulses for one cycle and `lvl` equals D/2 in that same cycle.
- R4: A read request from the accumulator when `lvl`=0 is an underflow. `unf` pulses for one cycle, no `rd_stb` is produced in that cycle, and `lvl` equals D/2.
- R5: While enabled, `wide_bw`=1 exactly when `lvl`<=2 or `lvl`>=D-2.
- R6: `bw_code` is 0 while wide. Otherwise it is 3 in T1 mode, 2 in E1 with `e1_slow_bw`=1, and 1 in E1 with `e1_slow_bw`=0.
- R7: With `en`=0, `rd_bit` equals `wr_bit` and `rd_stb` equals `wr_stb` in the same cycle, and `ovf`, `unf` and `wide_bw` stay 0.
- R8: When fill is above D/2, the per-cycle increment is the nominal value plus the correction constant shifted right by the mode's shift. Below D/2 it is the nominal value minus that amount. The resulting loop tracks input at the nominal rate, at about 6% above or below it, and with bursty spacing, with no overflow or underflow.
- R9: A change of D while enabled re-initialises the store, and `lvl` reads the new D/2 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; 0 selects bypass |
| line_e1 | input | 1 | 1 = E1 line mode, 0 = T1 |
| e1_slow_bw | input | 1 | E1 only: selects the slowest loop (forces 64-bit depth) |
| deep_sel | input | 1 | Selects the 64-bit store |
| wr_bit | input | 1 | Incoming data bit |
| wr_stb | input | 1 | Recovered-clock write strobe |
| rd_bit | output | 1 | Smoothed data bit |
| rd_stb | output | 1 | Smoothed read strobe |
| ovf | output | 1 | One-cycle overflow flag |
| unf | output | 1 | One-cycle underflow flag |
| wide_bw | output | 1 | Loop is in the wide-bandwidth guard band |
| bw_code | output | 2 | Active loop setting (0 wide, 1 E1 fast, 2 E1 slow, 3 T1) |
| lvl | output | 7 | Current store fill in bits |

## Verification
The bench builds the block with a 12-bit accumulator, a nominal increment of 256 (one read per 16 cycles), a correction constant of 128, and shifts 1, 2, 3 and 4. Each loop setting therefore moves the read rate by a distinct, visible amount, and the increment always stays positive. These values let an unthrottled write burst overflow both depths within a few dozen cycles, and let an idle input drain the store into underflow within a few hundred. Offset write rates of 1/15 and 1/17 push the fill into the guard band, so the switch between wide and narrow operation happens during long tracking runs while every bit is compared against a reference queue.

// File: rtl/jas_pkg.sv
package jas_pkg;

  typedef enum logic [1:0] {
    BW_WIDE    = 2'd0,
    BW_E1_FAST = 2'd1,
    BW_E1_SLOW = 2'd2,
    BW_T1      = 2'd3
  } bw_e;

  // Store depth actually in use.
  function automatic int active_depth(logic deep_sel, logic e1, logic e1_slow,
                                      int small_d, int large_d);
    return (deep_sel || (e1 && e1_slow)) ? large_d : small_d;
  endfunction

  // True when the fill sits inside the guard band at either end.
  function automatic logic near_edge(int fill, int depth, int guard);
    return (fill <= guard) || (fill >= depth - guard);
  endfunction

  function automatic bw_e pick_bw(logic wide, logic e1, logic e1_slow);
    if (wide)    return BW_WIDE;
    if (!e1)     return BW_T1;
    if (e1_slow) return BW_E1_SLOW;
    return BW_E1_FAST;
  endfunction

  function automatic int pick_shift(bw_e c, int sh_wide, int sh_e1f,
                                    int sh_e1s, int sh_t1);
    case (c)
      BW_WIDE:    return sh_wide;
      BW_E1_FAST: return sh_e1f;
      BW_E1_SLOW: return sh_e1s;
      default:    return sh_t1;
    endcase
  endfunction

  // Per-cycle accumulator increment: nominal plus a sign-driven correction.
  function automatic int nco_step(int nom, int corr_full, int sh,
                                  int fill, int depth, int acc_w);
    int c;
    int s;
    int top;
    c   = corr_full >>> sh;
    top = (1 << acc_w) - 1;
    if (2 * fill > depth)      s = nom + c;
    else if (2 * fill < depth) s = nom - c;
    else                       s = nom;
    if (s < 1)   s = 1;
    if (s > top) s = top;
    return s;
  endfunction

endpackage

// File: rtl/jas_bitfifo.sv
module jas_bitfifo #(
  parameter int DEPTH_LG = 64,
  parameter int PW = $clog2(DEPTH_LG),
  parameter int FW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          act,
  input  logic [FW-1:0] depth,
  input  logic          wr_stb,
  input  logic          wr_bit,
  input  logic          rd_req,
  output logic          rd_bit,
  output logic          rd_vld,
  output logic [FW-1:0] fill,
  output logic          ovf_evt,
  output logic          unf_evt
);

  logic [DEPTH_LG-1:0] mem;
  logic [PW-1:0]       wr_ptr, rd_ptr, wr_nxt;
  logic [FW-1:0]       half;
  logic                wr_go, rd_go, full_w, empty_w, rd_do, wr_do;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p, logic [FW-1:0] d);
    return (FW'(p) == d - FW'(1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_back_half(logic [PW-1:0] p, logic [FW-1:0] h);
    return (FW'(p) >= h) ? p - PW'(h) : p + PW'(h);
  endfunction

  assign half    = depth >> 1;
  assign wr_go   = act && wr_stb;
  assign rd_go   = act && rd_req;
  assign full_w  = (fill == depth);
  assign empty_w = (fill == '0);
  assign unf_evt = rd_go && empty_w;
  assign rd_do   = rd_go && !empty_w;
  assign ovf_evt = wr_go && full_w && !rd_do;
  assign wr_do   = wr_go && !ovf_evt;
  assign wr_nxt  = wr_do ? ptr_inc(wr_ptr, depth) : wr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      rd_vld <= 1'b0;
      rd_bit <= 1'b0;
    end else if (init) begin
      mem    <= '0;
      wr_ptr <= PW'(half);
      rd_ptr <= '0;
      fill   <= half;
      rd_vld <= 1'b0;
      rd_bit <= 1'b0;
    end else begin
      rd_vld <= rd_do;
      if (rd_do) rd_bit <= mem[rd_ptr];
      if (wr_do) mem[wr_ptr] <= wr_bit;
      wr_ptr <= wr_nxt;
      if (ovf_evt || unf_evt) begin
        rd_ptr <= ptr_back_half(wr_nxt, half);
        fill   <= half;
      end else begin
        if (rd_do) rd_ptr <= ptr_inc(rd_ptr, depth);
        fill <= fill + FW'(wr_do) - FW'(rd_do);
      end
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH_LG));

  assert_ovf_recentre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !init) |=> (fill == $past(half)));

  assert_unf_recentre_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_evt && !init) |=> (!rd_vld && fill == $past(half)));

  assert_read_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> ($past(fill) != '0));

endmodule

// File: rtl/jas_phase_nco.sv
module jas_phase_nco #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [ACC_W-1:0] step,
  output logic             tick
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc} + {1'b0, step};
  assign tick = run && sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (run) acc <= sum[ACC_W-1:0];
  end

  assert_acc_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && step != '0) |=> (acc != $past(acc)));

endmodule

// File: rtl/jas_loop_ctrl.sv
module jas_loop_ctrl
  import jas_pkg::*;
#(
  parameter int FW         = 7,
  parameter int ACC_W      = 16,
  parameter int NOM_INC    = 4096,
  parameter int CORR_FULL  = 2048,
  parameter int GUARD      = 2,
  parameter int SH_WIDE    = 2,
  parameter int SH_E1_FAST = 4,
  parameter int SH_E1_SLOW = 8,
  parameter int SH_T1      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [FW-1:0]    fill,
  input  logic [FW-1:0]    depth,
  input  logic             e1,
  input  logic             e1_slow,
  output logic             wide,
  output bw_e              code,
  output logic [ACC_W-1:0] step
);

  logic edge_w;
  int   sh;

  assign edge_w = near_edge(int'(fill), int'(depth), GUARD);
  assign wide   = en && edge_w;
  assign code   = pick_bw(edge_w, e1, e1_slow);
  assign sh     = pick_shift(code, SH_WIDE, SH_E1_FAST, SH_E1_SLOW, SH_T1);
  assign step   = ACC_W'(nco_step(NOM_INC, CORR_FULL, sh, int'(fill),
                                  int'(depth), ACC_W));

  assert_centre_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({fill, 1'b0} == {1'b0, depth}) |-> !wide);

endmodule

// File: rtl/rx_jitter_smoother.sv
module rx_jitter_smoother
  import jas_pkg::*;
#(
  parameter int DEPTH_SM   = 32,
  parameter int DEPTH_LG   = 64,
  parameter int ACC_W      = 16,
  parameter int NOM_INC    = 4096,
  parameter int CORR_FULL  = 2048,
  parameter int GUARD      = 2,
  parameter int SH_WIDE    = 2,
  parameter int SH_E1_FAST = 4,
  parameter int SH_E1_SLOW = 8,
  parameter int SH_T1      = 6,
  parameter int FW         = $clog2(DEPTH_LG) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          line_e1,
  input  logic          e1_slow_bw,
  input  logic          deep_sel,
  input  logic          wr_bit,
  input  logic          wr_stb,
  output logic          rd_bit,
  output logic          rd_stb,
  output logic          ovf,
  output logic          unf,
  output logic          wide_bw,
  output logic [1:0]    bw_code,
  output logic [FW-1:0] lvl
);

  logic             deep_w, en_q, deep_q, init, act;
  logic [FW-1:0]    depth;
  logic [ACC_W-1:0] step;
  logic             tick, f_bit, f_vld, ovf_evt, unf_evt, ovf_q, unf_q;
  bw_e              code;

  assign deep_w = (active_depth(deep_sel, line_e1, e1_slow_bw, 0, 1) == 1);
  assign depth  = deep_w ? FW'(DEPTH_LG) : FW'(DEPTH_SM);
  assign init   = en && (!en_q || (deep_w != deep_q));
  assign act    = en && !init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      deep_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      en_q   <= en;
      deep_q <= deep_w;
      ovf_q  <= act && ovf_evt;
      unf_q  <= act && unf_evt;
    end
  end

  jas_loop_ctrl #(
    .FW(FW), .ACC_W(ACC_W), .NOM_INC(NOM_INC), .CORR_FULL(CORR_FULL),
    .GUARD(GUARD), .SH_WIDE(SH_WIDE), .SH_E1_FAST(SH_E1_FAST),
    .SH_E1_SLOW(SH_E1_SLOW), .SH_T1(SH_T1)
  ) u_loop (
    .clk(clk), .rst_n(rst_n), .en(en), .fill(lvl), .depth(depth),
    .e1(line_e1), .e1_slow(e1_slow_bw), .wide(wide_bw), .code(code),
    .step(step)
  );

  jas_phase_nco #(.ACC_W(ACC_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .clr(!act), .run(act), .step(step), .tick(tick)
  );

  jas_bitfifo #(.DEPTH_LG(DEPTH_LG)) u_fifo (
    .clk(clk), .rst_n(rst_n), .init(init), .act(act), .depth(depth),
    .wr_stb(wr_stb), .wr_bit(wr_bit), .rd_req(tick), .rd_bit(f_bit),
    .rd_vld(f_vld), .fill(lvl), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  assign bw_code = code;
  assign rd_bit  = en ? f_bit : wr_bit;
  assign rd_stb  = en ? f_vld : wr_stb;
  assign ovf     = en && ovf_q;
  assign unf     = en && unf_q;

  assert_init_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (lvl == ($past(depth) >> 1)));

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ovf_q && !unf_q && !f_vld));

  assert_wide_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wide_bw |-> (bw_code == BW_WIDE));

  assert_no_flag_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

endmodule

// File: tb/sim_rx_jitter_smoother.sv
`timescale 1ns/1ps
module sim_rx_jitter_smoother;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, line_e1 = 1'b0, e1_slow_bw = 1'b0, deep_sel = 1'b0;
  logic wr_bit = 1'b0, wr_stb = 1'b0;
  logic rd_bit, rd_stb, ovf, unf, wide_bw;
  logic [1:0] bw_code;
  logic [6:0] lvl;

  int  n_chk = 0, n_fail = 0;
  bit  chk_on = 0, data_on = 0, track_on = 0;
  bit  model[$];

  always #2 clk = ~clk;

  rx_jitter_smoother #(
    .ACC_W(12), .NOM_INC(256), .CORR_FULL(128), .SH_WIDE(1),
    .SH_E1_FAST(2), .SH_T1(3), .SH_E1_SLOW(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .line_e1(line_e1),
    .e1_slow_bw(e1_slow_bw), .deep_sel(deep_sel), .wr_bit(wr_bit),
    .wr_stb(wr_stb), .rd_bit(rd_bit), .rd_stb(rd_stb), .ovf(ovf),
    .unf(unf), .wide_bw(wide_bw), .bw_code(bw_code), .lvl(lvl)
  );

  function automatic int tb_depth();
    return (deep_sel || (line_e1 && e1_slow_bw)) ? 64 : 32;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Per-cycle monitor: guard band (R5), loop code (R6), data order (R2), tracking (R8)
  always @(negedge clk) begin
    if (chk_on) begin
      int  d;
      bit  w;
      int  c;
      d = tb_depth();
      w = (lvl <= 2) || (int'(lvl) >= d - 2);
      c = w ? 0 : (!line_e1 ? 3 : (e1_slow_bw ? 2 : 1));
      chk(wide_bw == w, "R5", wide_bw, w);
      chk(int'(bw_code) == c, "R6", bw_code, c);
      if (track_on) chk(!ovf && !unf, "R8", {ovf, unf}, 0);
      if (data_on && rd_stb) begin
        if (model.size() == 0) chk(0, "R2", rd_bit, -1);
        else begin
          bit e;
          e = model.pop_front();
          chk(rd_bit == e, "R2", rd_bit, e);
        end
      end
    end
  end

  task automatic start(input bit e1, input bit slow, input bit deep);
    @(negedge clk);
    chk_on = 0; data_on = 0; track_on = 0;
    en = 0; wr_stb = 0;
    @(negedge clk);
    line_e1 = e1; e1_slow_bw = slow; deep_sel = deep; en = 1;
    @(posedge clk);
    model.delete();
    for (int i = 0; i < tb_depth() / 2; i++) model.push_back(1'b0);
    @(negedge clk);
    chk(int'(lvl) == tb_depth() / 2, "R1", lvl, tb_depth() / 2);
    chk_on = 1; data_on = 1;
  endtask

  // Writes n bits, spacing alternating between gap_a and gap_b cycles
  task automatic stream(input int n, input int gap_a, input int gap_b);
    for (int i = 0; i < n; i++) begin
      int g;
      bit b;
      g = (i % 2 == 0) ? gap_a : gap_b;
      b = ((i * 5) % 7 > 2) ^ (i[3]);
      wr_bit = b; wr_stb = 1;
      if (data_on) model.push_back(b);
      @(negedge clk);
      wr_stb = 0;
      for (int k = 1; k < g; k++) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(rd_stb == 0 && ovf == 0 && unf == 0, "R7", {rd_stb, ovf, unf}, 0);
    chk(wide_bw == 0 && lvl == 0, "R7", lvl, 0);
  endtask

  task automatic t_bypass;
    @(negedge clk);
    en = 0; wr_bit = 1; wr_stb = 1;
    #1 chk(rd_bit == 1 && rd_stb == 1, "R7", {rd_bit, rd_stb}, 3);
    @(negedge clk);
    wr_bit = 0; wr_stb = 1;
    #1 chk(rd_bit == 0 && rd_stb == 1, "R7", {rd_bit, rd_stb}, 1);
    @(negedge clk);
    wr_bit = 1; wr_stb = 0;
    #1 chk(rd_stb == 0 && rd_bit == 1 && !ovf && !unf && !wide_bw, "R7",
           {rd_stb, ovf, unf, wide_bw}, 0);
  endtask

  task automatic t_depths;
    start(0, 0, 0);  // 32
    start(0, 0, 1);  // 64
    start(1, 1, 0);  // forced 64 by slow E1 setting
    start(1, 0, 0);  // 32
    start(0, 1, 0);  // slow select ignored in T1: 32 (R1)
  endtask

  task automatic t_depth_change;
    start(0, 0, 0);
    @(negedge clk);
    data_on = 0; deep_sel = 1;
    @(negedge clk);
    chk(lvl == 32, "R9", lvl, 32);
    start(1, 1, 0);
    @(negedge clk);
    data_on = 0; e1_slow_bw = 0;
    @(negedge clk);
    chk(lvl == 16, "R9", lvl, 16);
  endtask

  task automatic t_overflow(input bit deep);
    bit seen;
    seen = 0;
    start(0, 0, deep);
    data_on = 0;
    for (int i = 0; i < 500 && !seen; i++) begin
      wr_bit = 1; wr_stb = 1;
      @(negedge clk);
      if (ovf) begin
        seen = 1;
        chk(int'(lvl) == tb_depth() / 2, "R3", lvl, tb_depth() / 2);
      end
    end
    wr_stb = 0;
    chk(seen, "R3", seen, 1);
  endtask

  task automatic t_underflow;
    bit seen;
    seen = 0;
    start(1, 0, 0);
    data_on = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (unf) begin
        seen = 1;
        chk(lvl == 16 && rd_stb == 0, "R4", {rd_stb, lvl}, 16);
      end
    end
    chk(seen, "R4", seen, 1);
  endtask

  task automatic t_track(input bit e1, input bit slow, input int ga, input int gb);
    start(e1, slow, 0);
    track_on = 1;
    stream(250, ga, gb);
    track_on = 0;
    chk(model.size() <= 64, "R8", model.size(), 64);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_depths();
    t_depth_change();
    t_track(0, 0, 16, 16);  // nominal rate, T1
    t_track(1, 0, 15, 15);  // fast input, E1 fast loop
    t_track(1, 1, 8, 24);   // bursty input, E1 slow loop
    t_track(0, 0, 17, 17);  // slow input, T1
    t_overflow(0);
    t_overflow(1);
    t_underflow();
    chk_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule